// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Controller

The controller watches two active-low push-buttons and raises a system reset only when both are held together for a long, selectable time. Timing advances on a clock-enable tick from a slow oscillator. A static select input picks the shorter or the longer of two hold delays. The delay limits are tick counts set by parameters: 75 and 125 ticks by default, which is 7.5 s and 12.5 s at a 10 Hz tick.

The reset is driven on two outputs of opposite polarity. They always carry the same state. The reset lasts exactly as long as both buttons stay pressed. There is no minimum pulse width and no pulse at power-up. A supply-good input stands in for an undervoltage detector. While it is low, the buttons are ignored, the timer is cleared and the reset is held off.

Top module: `long_press_reset`

## Requirements
- R1: Button inputs are active low (0 = pressed) and each passes through a two-flop synchroniser. The timer advances only while both synchronised buttons read pressed. Holding one button alone never produces a reset.
- R2: With `delay_sel_i` = 0 the reset asserts at the clock edge that samples the 75th tick counted during a joint hold. With `delay_sel_i` = 1 it asserts at the 125th such tick. One tick fewer never asserts it.
- R3: `reset_o` (active high) and `reset_no` (active low) switch on the same edge, and `reset_no` always equals the inverse of `reset_o`.
- R4: Once asserted, the reset stays on while both buttons are held. It deasserts within three clock cycles of either button input going high.
- R5: Releasing either button before the delay expires clears the timer. A new joint press restarts the count from zero.
- R6: After a reset deasserts, no new timing starts until both buttons have been seen released.
- R7: While `supply_ok_i` is 0, the reset outputs are deasserted in the same cycle, the timer is cleared and the buttons have no effect. Timing restarts from zero after the supply returns.
- R8: After `rst_ni` is released, both outputs are deasserted. No reset is produced until a full hold delay has elapsed, even when both buttons are held through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle clock-enable tick from the slow oscillator |
| btn_a_ni | input | 1 | First push-button, active low, asynchronous |
| btn_b_ni | input | 1 | Second push-button, active low, asynchronous |
| delay_sel_i | input | 1 | Hold delay select: 0 = short, 1 = long |
| supply_ok_i | input | 1 | Supply-good flag, 0 = undervoltage |
| reset_o | output | 1 | Reset, active high |
| reset_no | output | 1 | Reset, active low |

## Verification
The expiring tick and an undervoltage drop can land in the same cycle. The bench lowers `supply_ok_i` and raises the final tick at the same falling edge. It then judges that no reset appears and that a complete new delay is needed once the supply returns. A second collision is the expiring count against an early release and re-press. A release shortly before the final tick must make the next attempt take the full delay again.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_TIMING = 2'd1,
    ST_FIRED  = 2'd2,
    ST_WAIT   = 2'd3
  } lpr_state_e;
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to released level (buttons idle high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '1;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lpr_timer.sv
module lpr_timer #(
  parameter int LO_TICKS = 75,
  parameter int HI_TICKS = 125,
  localparam int MaxTicks = (HI_TICKS > LO_TICKS) ? HI_TICKS : LO_TICKS,
  localparam int CntW = $clog2(MaxTicks + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic            sel_i,
  output logic            expire_o,
  output logic [CntW-1:0] cnt_o
);
  localparam logic [CntW-1:0] LoLast = CntW'(LO_TICKS - 1);
  localparam logic [CntW-1:0] HiLast = CntW'(HI_TICKS - 1);

  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] last;

  assign last     = sel_i ? HiLast : LoLast;
  assign expire_o = run_i && tick_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i || !run_i)       cnt_q <= '0;
    else if (tick_i && !expire_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl
  import lpr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       both_i,
  input  logic       none_i,
  input  logic       supply_ok_i,
  input  logic       expire_i,
  output logic       run_o,
  output logic       clr_o,
  output logic       fired_o
);
  lpr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_ARMED;
    end else begin
      unique case (state_q)
        ST_ARMED:  if (both_i) state_d = ST_TIMING;
        ST_TIMING: begin
          if (!both_i)       state_d = ST_ARMED;
          else if (expire_i) state_d = ST_FIRED;
        end
        ST_FIRED:  if (!both_i) state_d = none_i ? ST_ARMED : ST_WAIT;
        ST_WAIT:   if (none_i) state_d = ST_ARMED;
        default:   state_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARMED;
    else         state_q <= state_d;
  end

  assign run_o   = (state_q == ST_TIMING) && both_i && supply_ok_i;
  assign clr_o   = (state_q != ST_TIMING) || !supply_ok_i;
  assign fired_o = (state_q == ST_FIRED);
endmodule

// File: rtl/long_press_reset.sv
module long_press_reset #(
  parameter int DELAY_LO_TICKS = 75,
  parameter int DELAY_HI_TICKS = 125,
  parameter int SYNC_STAGES    = 2,
  localparam int MaxTicks = (DELAY_HI_TICKS > DELAY_LO_TICKS) ? DELAY_HI_TICKS : DELAY_LO_TICKS,
  localparam int CntW = $clog2(MaxTicks + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_a_ni,
  input  logic btn_b_ni,
  input  logic delay_sel_i,
  input  logic supply_ok_i,
  output logic reset_o,
  output logic reset_no
);
  logic [1:0]      btn_sync_n;
  logic            both_pressed;
  logic            none_pressed;
  logic            run, clr, expire, fired;
  logic [CntW-1:0] hold_cnt;

  lpr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({btn_b_ni, btn_a_ni}),
    .q_o    (btn_sync_n)
  );

  // ignore buttons entirely during undervoltage
  assign both_pressed = supply_ok_i && (btn_sync_n == 2'b00);
  assign none_pressed = (btn_sync_n == 2'b11);

  lpr_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .both_i      (both_pressed),
    .none_i      (none_pressed),
    .supply_ok_i (supply_ok_i),
    .expire_i    (expire),
    .run_o       (run),
    .clr_o       (clr),
    .fired_o     (fired)
  );

  lpr_timer #(.LO_TICKS(DELAY_LO_TICKS), .HI_TICKS(DELAY_HI_TICKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .run_i    (run),
    .tick_i   (tick_i),
    .sel_i    (delay_sel_i),
    .expire_o (expire),
    .cnt_o    (hold_cnt)
  );

  // undervoltage gate is combinational so outputs drop in the same cycle
  assign reset_o  = fired && supply_ok_i;
  assign reset_no = ~reset_o;
endmodule

// File: rtl/lpr_checker.sv
module lpr_checker #(
  parameter int CNT_W    = 7,
  parameter int HI_TICKS = 125
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             supply_ok_i,
  input logic             reset_o,
  input logic             reset_no,
  input logic             both_pressed,
  input logic [CNT_W-1:0] hold_cnt
);
  // R3
  polarity_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_no == !reset_o);

  // R2
  fire_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_o) |-> $past(tick_i));

  // R4
  release_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_o && !both_pressed) |=> !reset_o);

  // R7
  uv_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !reset_o);

  // R7
  uv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> hold_cnt == '0);

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cnt <= CNT_W'(HI_TICKS - 1));
endmodule

bind long_press_reset lpr_checker #(.CNT_W(CntW), .HI_TICKS(MaxTicks)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .supply_ok_i  (supply_ok_i),
  .reset_o      (reset_o),
  .reset_no     (reset_no),
  .both_pressed (both_pressed),
  .hold_cnt     (hold_cnt)
);

// File: tb/long_press_reset_test.sv
module long_press_reset_test;
  localparam int ClkPeriod = 10;
  localparam int LoTicks = 75;
  localparam int HiTicks = 125;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic btn_a_n = 1, btn_b_n = 1;
  logic sel = 0;
  logic sup_ok = 1;
  logic reset_o, reset_no;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  long_press_reset #(.DELAY_LO_TICKS(LoTicks), .DELAY_HI_TICKS(HiTicks)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .btn_a_ni(btn_a_n),
    .btn_b_ni(btn_b_n), .delay_sel_i(sel), .supply_ok_i(sup_ok),
    .reset_o(reset_o), .reset_no(reset_no)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic exp);
    check({req, " reset_o"}, reset_o, exp);
    check({req, " reset_no"}, reset_no, ~exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      wait_cyc(2);
    end
  endtask

  task automatic press_both();
    @(negedge clk) begin btn_a_n = 0; btn_b_n = 0; end
    wait_cyc(5);
  endtask

  task automatic release_both();
    @(negedge clk) begin btn_a_n = 1; btn_b_n = 1; end
    wait_cyc(5);
  endtask

  task automatic t_reset_state();
    btn_a_n = 0; btn_b_n = 0;
    wait_cyc(3);
    check_out("R8 during reset", 1'b0);
    @(negedge clk) rst_n = 1;
    wait_cyc(6);
    check_out("R8 after reset, buttons held", 1'b0);
    ticks(LoTicks - 1);
    check_out("R8 no early pulse", 1'b0);
    ticks(1);
    check_out("R8 full delay after reset", 1'b1);
    release_both();
    check_out("R8 released", 1'b0);
  endtask

  task automatic t_short_delay();
    sel = 0;
    press_both();
    ticks(LoTicks - 1);
    check_out("R2 short minus one", 1'b0);
    ticks(1);
    check_out("R2 R3 short expiry", 1'b1);
    wait_cyc(20);
    check_out("R4 held stays on", 1'b1);
    @(negedge clk) btn_a_n = 0;
    @(negedge clk) btn_a_n = 1;
    wait_cyc(4);
    check_out("R4 release drops", 1'b0);
    release_both();
  endtask

  task automatic t_long_delay();
    sel = 1;
    press_both();
    ticks(HiTicks - 1);
    check_out("R2 long minus one", 1'b0);
    ticks(1);
    check_out("R2 long expiry", 1'b1);
    release_both();
    check_out("R4 long released", 1'b0);
    sel = 0;
  endtask

  task automatic t_early_release();
    press_both();
    ticks(50);
    @(negedge clk) btn_b_n = 1;
    wait_cyc(4);
    @(negedge clk) btn_b_n = 0;
    wait_cyc(5);
    ticks(LoTicks - 1);
    check_out("R5 restart from zero", 1'b0);
    ticks(1);
    check_out("R5 full delay after restart", 1'b1);
    release_both();
  endtask

  task automatic t_rearm();
    press_both();
    ticks(LoTicks);
    check_out("R6 fired", 1'b1);
    @(negedge clk) btn_a_n = 1;
    wait_cyc(5);
    check_out("R6 dropped", 1'b0);
    @(negedge clk) btn_a_n = 0;
    wait_cyc(5);
    ticks(LoTicks + 5);
    check_out("R6 no rearm while one held", 1'b0);
    release_both();
    press_both();
    ticks(LoTicks);
    check_out("R6 rearm after full release", 1'b1);
    release_both();
  endtask

  task automatic t_one_button();
    @(negedge clk) btn_a_n = 0;
    wait_cyc(5);
    ticks(LoTicks + 25);
    check_out("R1 single button", 1'b0);
    release_both();
  endtask

  task automatic t_undervoltage();
    press_both();
    ticks(LoTicks);
    check_out("R7 fired before drop", 1'b1);
    @(negedge clk) sup_ok = 0;
    #1;
    check_out("R7 same-cycle drop", 1'b0);
    ticks(LoTicks + 5);
    check_out("R7 buttons ignored", 1'b0);
    @(negedge clk) sup_ok = 1;
    wait_cyc(3);
    ticks(LoTicks - 1);
    check_out("R7 timer cleared", 1'b0);
    ticks(1);
    check_out("R7 fires after full delay", 1'b1);
    release_both();
    // mid-timing drop
    press_both();
    ticks(60);
    @(negedge clk) sup_ok = 0;
    wait_cyc(3);
    @(negedge clk) sup_ok = 1;
    wait_cyc(3);
    ticks(20);
    check_out("R7 partial count lost", 1'b0);
    release_both();
  endtask

  task automatic t_collision();
    press_both();
    ticks(LoTicks - 1);
    @(negedge clk) begin sup_ok = 0; tick = 1; end
    @(negedge clk) tick = 0;
    check_out("R7 drop beats final tick", 1'b0);
    wait_cyc(3);
    check_out("R7 drop beats final tick later", 1'b0);
    @(negedge clk) sup_ok = 1;
    wait_cyc(3);
    ticks(LoTicks - 1);
    check_out("R7 collision restart", 1'b0);
    ticks(1);
    check_out("R7 collision full delay", 1'b1);
    release_both();
  endtask

  initial begin
    t_reset_state();
    t_short_delay();
    t_long_delay();
    t_early_release();
    t_rearm();
    t_one_button();
    t_undervoltage();
    t_collision();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule